// File: doc/BRIEF.md
# Streaming Frame CRC Checker

This block checks the cyclic redundancy code of frames that arrive as a stream of W-bit samples. Each sample comes with start, end and valid strobes. The last M bits of every frame hold the checksum that the sender appended. The block runs the CRC over the rest of the frame, the payload, and compares the result with that trailing checksum. It passes the payload downstream with the checksum removed. The output stream carries its own start, end and valid strobes, and an error word is reported on the final payload sample.

The generator is chosen at build time from four polynomials: two of 24 bits, one of 16 bits and one of 8 bits. The state advances by W bits per accepted sample through a fixed linear network. The error can be reported in one of two forms. The first is the raw per-bit XOR of the computed and received checksums. The second is a single pass/fail flag, formed after a configurable mask (often a terminal identifier) has been folded into the comparison. Inside a frame, the output lags the input by M/W accepted samples. This lag is what lets the block withhold the checksum samples without any extra buffering.

Top module: `crc_frame_checker`

## Requirements
- R1: Parameter KIND selects the CRC width M and the generator: CRCK_24A is M=24 with 0x864CFB, CRCK_24B is M=24 with 0x800063, CRCK_16 is M=16 with 0x1021, and CRCK_8 is M=8 with 0x9B. The register starts at zero on each frame and has no final inversion. Bit W-1 of a sample is the earliest bit in the stream. SAMPLE_W must divide M.
- R2: For a frame of N accepted samples with N > D = M/W, the output carries input samples 0..N-D-1 in order with their data unchanged. Payload sample k appears on the cycle after input sample k+D is accepted.
- R3: out_start is 1 only with the first payload sample and out_end only with the last one, once each per complete frame. Neither is ever 1 while out_valid is 0.
- R4: With FULL_MISMATCH=1, err on the out_end cycle equals the computed CRC XOR the received checksum. The received checksum is the last M frame bits, earliest bit as bit M-1.
- R5: With FULL_MISMATCH=0, err[0] on the out_end cycle is 1 exactly when the computed CRC, the received checksum and CHK_MASK XOR to a nonzero value. The other err bits are 0.
- R6: err is zero on every cycle where out_end is 0.
- R7: A cycle with in_valid low, whatever its data, start or end, changes no state and produces no output sample.
- R8: Valid samples outside a start..end pair produce no output and do not affect the next frame.
- R9: A valid start inside an unfinished frame abandons that frame without an out_end and begins a fresh frame with that sample.
- R10: A frame of D or fewer samples produces no output sample. The cycle after an accepted start never carries out_valid.
- R11: While rst_n is low, all outputs are zero. rst_n is asynchronous, active low, and is released synchronously to clk outside this block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | SAMPLE_W | Input sample, earliest bit in the MSB |
| in_start | input | 1 | First sample of a frame |
| in_end | input | 1 | Last sample of a frame |
| in_valid | input | 1 | Qualifies in_data and the strobes |
| out_data | output | SAMPLE_W | Payload sample |
| out_start | output | 1 | First payload sample |
| out_end | output | 1 | Last payload sample; err valid |
| out_valid | output | 1 | Qualifies out_data and the strobes |
| err | output | M | Mismatch word, or flag in bit 0 |

## Verification
The bench sweeps payload lengths and flips each checksum bit one at a time. A design that reversed bit order or misaligned the checksum would then report a mismatch word other than the single flipped bit, or would fail frames that are good. It adds invalid cycles carrying bogus start and end strobes, stray valid samples outside any frame, and an aborted frame followed by a good one. These catch a state that advances on invalid cycles, an output left over from an abandoned frame, or an end strobe that was never cleared. It also sends frames that consist of nothing but checksum, or a single sample. A delay line that was miscounted would let checksum samples leak into the output or drop the last payload sample.

// File: rtl/crc_chk_pkg.sv
package crc_chk_pkg;

  typedef enum logic [1:0] {
    CRCK_24A = 2'd0,
    CRCK_24B = 2'd1,
    CRCK_16  = 2'd2,
    CRCK_8   = 2'd3
  } crc_kind_e;

  // Register width of each generator.
  function automatic int kind_width(input crc_kind_e k);
    case (k)
      CRCK_24A: return 24;
      CRCK_24B: return 24;
      CRCK_16:  return 16;
      default:  return 8;
    endcase
  endfunction

  // Generator taps, x^M term implied.
  function automatic logic [23:0] kind_poly(input crc_kind_e k);
    case (k)
      CRCK_24A: return 24'h864CFB;
      CRCK_24B: return 24'h800063;
      CRCK_16:  return 24'h001021;
      default:  return 24'h00009B;
    endcase
  endfunction

endpackage

// File: rtl/crc_step_net.sv
// W-bit parallel CRC update, X' = F*X xor G*D. The columns of F and G
// are derived at elaboration by pushing unit vectors through a serial step.
module crc_step_net #(
  parameter int          M    = 24,
  parameter int          W    = 8,
  parameter logic [M-1:0] POLY = '0
) (
  input  logic [M-1:0] state,
  input  logic [W-1:0] din,
  output logic [M-1:0] nxt
);

  function automatic logic [M-1:0] serial_step(input logic [M-1:0] st,
                                               input logic [W-1:0] dw);
    logic [M-1:0] s;
    logic         fb;
    s = st;
    for (int b = W - 1; b >= 0; b--) begin
      fb = s[M-1] ^ dw[b];
      s  = {s[M-2:0], 1'b0};
      if (fb) s = s ^ POLY;
    end
    return s;
  endfunction

  localparam logic [M-1:0] ONE_M = {{(M-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] ONE_W = {{(W-1){1'b0}}, 1'b1};

  logic [M-1:0] st_term [M];
  logic [M-1:0] dt_term [W];

  for (genvar c = 0; c < M; c++) begin : g_state_col
    localparam logic [M-1:0] COL = serial_step(ONE_M << c, '0);
    assign st_term[c] = state[c] ? COL : '0;
  end

  for (genvar d = 0; d < W; d++) begin : g_data_col
    localparam logic [M-1:0] COL = serial_step('0, ONE_W << d);
    assign dt_term[d] = din[d] ? COL : '0;
  end

  always_comb begin
    nxt = '0;
    for (int c = 0; c < M; c++) nxt = nxt ^ st_term[c];
    for (int d = 0; d < W; d++) nxt = nxt ^ dt_term[d];
  end

endmodule

// File: rtl/crc_hold_line.sv
// D-deep shift line that withholds the trailing checksum samples.
module crc_hold_line #(
  parameter int W = 8,
  parameter int D = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         push_tag,
  output logic [W-1:0] oldest_data,
  output logic         oldest_tag,
  output logic [W*D-1:0] tail_word
);

  logic [W-1:0] ent_d_q [D];
  logic [W-1:0] ent_d_n [D];
  logic         ent_t_q [D];
  logic         ent_t_n [D];

  always_comb begin
    for (int i = 0; i < D; i++) begin
      ent_d_n[i] = ent_d_q[i];
      ent_t_n[i] = ent_t_q[i];
    end
    if (push) begin
      for (int i = 0; i < D - 1; i++) begin
        ent_d_n[i] = ent_d_q[i+1];
        ent_t_n[i] = ent_t_q[i+1];
      end
      ent_d_n[D-1] = push_data;
      ent_t_n[D-1] = push_tag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < D; i++) begin
        ent_d_q[i] <= '0;
        ent_t_q[i] <= 1'b0;
      end
    end else if (push) begin
      for (int i = 0; i < D; i++) begin
        ent_d_q[i] <= ent_d_n[i];
        ent_t_q[i] <= ent_t_n[i];
      end
    end
  end

  assign oldest_data = ent_d_q[0];
  assign oldest_tag  = ent_t_q[0];

  // Checksum as it stands once the current sample is pushed: entries
  // 1..D-1 (earliest first) followed by the incoming sample.
  assign tail_word[W-1:0] = push_data;
  for (genvar i = 1; i < D; i++) begin : g_tail
    assign tail_word[(D-i)*W +: W] = ent_d_q[i];
  end

endmodule

// File: rtl/crc_err_fold.sv
// Reduces computed and received checksums to the reported error word.
module crc_err_fold #(
  parameter int           M    = 24,
  parameter bit           FULL = 1'b1,
  parameter logic [M-1:0] MASK = '0
) (
  input  logic [M-1:0] calc,
  input  logic [M-1:0] rx,
  output logic [M-1:0] err
);

  if (FULL) begin : g_full
    assign err = calc ^ rx;
  end else begin : g_flag
    assign err = {{(M-1){1'b0}}, |(calc ^ rx ^ MASK)};
  end

endmodule

// File: rtl/crc_frame_checker.sv
module crc_frame_checker
  import crc_chk_pkg::*;
#(
  parameter crc_kind_e   KIND          = CRCK_24A,
  parameter int          SAMPLE_W      = 8,
  parameter bit          FULL_MISMATCH = 1'b1,
  parameter logic [23:0] CHK_MASK      = 24'h000000,
  localparam int         M             = kind_width(KIND)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] in_data,
  input  logic                in_start,
  input  logic                in_end,
  input  logic                in_valid,
  output logic [SAMPLE_W-1:0] out_data,
  output logic                out_start,
  output logic                out_end,
  output logic                out_valid,
  output logic [M-1:0]        err
);

  localparam int          D         = M / SAMPLE_W;
  localparam int          FILL_W    = $clog2(D + 1);
  localparam logic [23:0] POLY_FULL = kind_poly(KIND);
  localparam logic [M-1:0] POLY     = POLY_FULL[M-1:0];
  localparam logic [M-1:0] MASK     = CHK_MASK[M-1:0];

  // frame and crc state
  logic              in_frame_q, in_frame_n;
  logic [FILL_W-1:0] fill_q, fill_n;
  logic [M-1:0]      crc_q, crc_n;

  // output registers
  logic [SAMPLE_W-1:0] o_data_q;
  logic                o_start_q, o_start_n;
  logic                o_end_q, o_end_n;
  logic                o_valid_q, o_valid_n;
  logic [M-1:0]        o_err_q, o_err_n;

  // datapath wires
  logic                take, restart, emit, line_full;
  logic [SAMPLE_W-1:0] oldest_data;
  logic                oldest_tag;
  logic [M-1:0]        tail_word;
  logic [M-1:0]        crc_step;
  logic [M-1:0]        err_word;

  crc_hold_line #(
    .W (SAMPLE_W),
    .D (D)
  ) u_line (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (take),
    .push_data  (in_data),
    .push_tag   (in_start),
    .oldest_data(oldest_data),
    .oldest_tag (oldest_tag),
    .tail_word  (tail_word)
  );

  crc_step_net #(
    .M    (M),
    .W    (SAMPLE_W),
    .POLY (POLY)
  ) u_step (
    .state(crc_q),
    .din  (oldest_data),
    .nxt  (crc_step)
  );

  crc_err_fold #(
    .M    (M),
    .FULL (FULL_MISMATCH),
    .MASK (MASK)
  ) u_fold (
    .calc(crc_step),
    .rx  (tail_word),
    .err (err_word)
  );

  always_comb begin
    take      = in_valid & (in_start | in_frame_q);
    restart   = in_valid & in_start;
    line_full = (fill_q == FILL_W'(D));
    emit      = take & ~in_start & line_full;

    in_frame_n = in_frame_q;
    if (take) in_frame_n = ~in_end;

    fill_n = fill_q;
    if (restart)               fill_n = FILL_W'(1);
    else if (take && !line_full) fill_n = fill_q + FILL_W'(1);

    crc_n = crc_q;
    if (restart)   crc_n = '0;
    else if (emit) crc_n = crc_step;

    o_valid_n = emit;
    o_start_n = emit & oldest_tag;
    o_end_n   = emit & in_end;
    o_err_n   = (emit & in_end) ? err_word : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      fill_q     <= '0;
      crc_q      <= '0;
    end else begin
      in_frame_q <= in_frame_n;
      fill_q     <= fill_n;
      crc_q      <= crc_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_valid_q <= 1'b0;
      o_start_q <= 1'b0;
      o_end_q   <= 1'b0;
      o_err_q   <= '0;
    end else begin
      o_valid_q <= o_valid_n;
      o_start_q <= o_start_n;
      o_end_q   <= o_end_n;
      o_err_q   <= o_err_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    o_data_q <= '0;
    else if (emit) o_data_q <= oldest_data;
  end

  assign out_data  = o_data_q;
  assign out_start = o_start_q;
  assign out_end   = o_end_q;
  assign out_valid = o_valid_q;
  assign err       = o_err_q;

endmodule

// File: rtl/crc_frame_checker_sva.sv
module crc_frame_checker_sva #(
  parameter int M = 24
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_start,
  input logic         in_end,
  input logic         in_valid,
  input logic         out_start,
  input logic         out_end,
  input logic         out_valid,
  input logic [M-1:0] err
);

  assert_flags_need_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_start || out_end) |-> out_valid);

  assert_single_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_end |=> !out_end);

  assert_err_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_end |-> (err == '0));

  assert_output_needs_input_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  assert_end_needs_input_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_end |-> $past(in_end));

  assert_start_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_start) |=> !out_valid);

  assert_reset_quiet_R11: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && err == '0));

endmodule

bind crc_frame_checker crc_frame_checker_sva #(.M(M)) u_sva (.*);

// File: tb/crc_frame_checker_test.sv
module crc_frame_checker_test;
  import crc_chk_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] in_data = '0;
  logic in_start = 1'b0, in_end = 1'b0, in_valid = 1'b0;

  logic [3:0]  od_a, od_b;
  logic        os_a, oe_a, ov_a, os_b, oe_b, ov_b;
  logic [15:0] err_a;
  logic [7:0]  err_b;

  always #5 clk = ~clk;

  // 16-bit CRC, raw mismatch word
  crc_frame_checker #(.KIND(CRCK_16), .SAMPLE_W(4), .FULL_MISMATCH(1'b1),
                      .CHK_MASK(24'h0)) uut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_start(in_start),
    .in_end(in_end), .in_valid(in_valid), .out_data(od_a), .out_start(os_a),
    .out_end(oe_a), .out_valid(ov_a), .err(err_a));

  // 8-bit CRC, masked flag
  crc_frame_checker #(.KIND(CRCK_8), .SAMPLE_W(4), .FULL_MISMATCH(1'b0),
                      .CHK_MASK(24'h00005A)) uut_flag (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_start(in_start),
    .in_end(in_end), .in_valid(in_valid), .out_data(od_b), .out_start(os_b),
    .out_end(oe_b), .out_valid(ov_b), .err(err_b));

  int n_chk = 0;
  int n_err = 0;

  logic [3:0] fr [0:63];
  int flen;

  logic [3:0] cap_d [0:1][0:63];
  logic       cap_s [0:1][0:63];
  logic       cap_e [0:1][0:63];
  int         cnt [0:1];
  logic [15:0] err_cap [0:1];
  bit          bad_err [0:1];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Reference CRC over the first nbits of fr, earliest bit first.
  function automatic logic [15:0] crc_ref(input int m, input logic [15:0] poly,
                                          input int nbits);
    logic [15:0] r = '0;
    logic [15:0] msk = (m == 16) ? 16'hFFFF : 16'h00FF;
    for (int i = 0; i < nbits; i++) begin
      logic b = fr[i/4][3 - (i % 4)];
      logic fb = r[m-1] ^ b;
      r = (r << 1) & msk;
      if (fb) r = r ^ poly;
    end
    return r;
  endfunction

  function automatic logic [15:0] tail_bits(input int m);
    logic [15:0] t = '0;
    for (int i = flen * 4 - m; i < flen * 4; i++)
      t = {t[14:0], fr[i/4][3 - (i % 4)]};
    return t;
  endfunction

  task automatic clear_caps();
    for (int k = 0; k < 2; k++) begin
      cnt[k] = 0; err_cap[k] = '0; bad_err[k] = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (ov_a) begin
        if (cnt[0] < 64) begin
          cap_d[0][cnt[0]] = od_a; cap_s[0][cnt[0]] = os_a; cap_e[0][cnt[0]] = oe_a;
        end
        cnt[0]++;
      end
      if (ov_b) begin
        if (cnt[1] < 64) begin
          cap_d[1][cnt[1]] = od_b; cap_s[1][cnt[1]] = os_b; cap_e[1][cnt[1]] = oe_b;
        end
        cnt[1]++;
      end
      if (oe_a) err_cap[0] = err_a;
      if (oe_b) err_cap[1] = {8'h00, err_b};
      if (!oe_a && err_a != '0) bad_err[0] = 1'b1;
      if (!oe_b && err_b != '0) bad_err[1] = 1'b1;
    end
  end

  task automatic drive(input logic [3:0] d, input logic s, input logic e, input logic v);
    @(negedge clk); #1;
    in_data = d; in_start = s; in_end = e; in_valid = v;
  endtask

  task automatic flush();
    repeat (6) drive(4'h0, 1'b0, 1'b0, 1'b0);
  endtask

  // gaps: invalid cycles with bogus strobes inside the frame (R7)
  task automatic send_frame(input bit gaps);
    for (int i = 0; i < flen; i++) begin
      drive(fr[i], i == 0, i == flen - 1, 1'b1);
      if (gaps && (i % 3 == 1)) drive(~fr[i], 1'b1, 1'b1, 1'b0);
    end
    flush();
  endtask

  task automatic build_payload(input int n, input int seed);
    flen = n;
    for (int i = 0; i < n; i++) fr[i] = 4'((i * 7 + seed * 3 + 5) ^ (seed >> 1));
  endtask

  task automatic append16();
    logic [15:0] c = crc_ref(16, 16'h1021, flen * 4);
    for (int i = 0; i < 4; i++) fr[flen + i] = c[15 - 4*i -: 4];
    flen += 4;
  endtask

  task automatic append8();
    logic [7:0] c = crc_ref(8, 16'h009B, flen * 4) ^ 8'h5A;
    fr[flen] = c[7:4]; fr[flen + 1] = c[3:0];
    flen += 2;
  endtask

  // Compare captured output of instance k (D = dk) against fr.
  task automatic check_inst(input int k, input int dk, input string tag);
    int n = (flen > dk) ? flen - dk : 0;
    bit dok = 1'b1, sok = 1'b1, eok = 1'b1;
    logic [15:0] exp_err;
    check(cnt[k] == n, "R2", {tag, " payload count"}, cnt[k], n);
    if (cnt[k] == n) begin
      for (int i = 0; i < n; i++) begin
        if (cap_d[k][i] != fr[i]) dok = 1'b0;
        if (cap_s[k][i] != (i == 0)) sok = 1'b0;
        if (cap_e[k][i] != (i == n - 1)) eok = 1'b0;
      end
      check(dok, "R2", {tag, " payload data"}, dok, 1);
      check(sok, "R3", {tag, " start strobe"}, sok, 1);
      check(eok, "R3", {tag, " end strobe"}, eok, 1);
    end
    if (n > 0) begin
      if (k == 0) begin
        exp_err = crc_ref(16, 16'h1021, (flen - 4) * 4) ^ tail_bits(16);
        check(err_cap[0] == exp_err, "R4", {tag, " mismatch word"}, err_cap[0], exp_err);
      end else begin
        exp_err = {15'd0, |(crc_ref(8, 16'h009B, (flen - 2) * 4) ^ tail_bits(8) ^ 16'h005A)};
        check(err_cap[1] == exp_err, "R5", {tag, " masked flag"}, err_cap[1], exp_err);
      end
    end
    check(!bad_err[k], "R6", {tag, " err outside end"}, bad_err[k], 0);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    clear_caps();
    repeat (3) @(negedge clk);
    // R11: outputs quiet in reset
    check({ov_a, os_a, oe_a, ov_b, os_b, oe_b} == 6'b0, "R11", "strobes in reset",
          {ov_a, os_a, oe_a, ov_b, os_b, oe_b}, 0);
    check(err_a == '0 && err_b == '0, "R11", "err in reset", {err_a, err_b}, 0);
    #1 rst_n = 1'b1;
    flush();

    // R1: good 16-bit frames over a sweep of payload lengths
    for (int n = 1; n <= 12; n++) begin
      clear_caps();
      build_payload(n, n);
      append16();
      send_frame(1'b0);
      check(err_cap[0] == 16'h0, "R1", "good crc16 frame", err_cap[0], 0);
      check_inst(0, 4, "crc16");
      check_inst(1, 2, "crc8");
    end

    // R1, R5: frames good under the masked 8-bit check
    for (int n = 1; n <= 10; n++) begin
      clear_caps();
      build_payload(n, n + 20);
      append8();
      send_frame(1'b0);
      check(err_cap[1] == 16'h0, "R1", "good masked crc8 frame", err_cap[1], 0);
      check_inst(0, 4, "crc16");
      check_inst(1, 2, "crc8");
    end

    // R4: each single checksum bit flip shows as exactly that bit
    for (int j = 0; j < 16; j++) begin
      clear_caps();
      build_payload(6, 3);
      append16();
      fr[flen - 1 - j/4][j % 4] = ~fr[flen - 1 - j/4][j % 4];
      send_frame(1'b0);
      check(err_cap[0] == (16'h1 << j), "R4", "single bit flip", err_cap[0], 16'h1 << j);
      check_inst(1, 2, "crc8 flip");
    end

    // R7: invalid cycles with bogus strobes inside the frame
    for (int n = 2; n <= 8; n += 3) begin
      clear_caps();
      build_payload(n, 40 + n);
      append16();
      send_frame(1'b1);
      check(err_cap[0] == 16'h0, "R7", "gapped frame result", err_cap[0], 0);
      check_inst(0, 4, "crc16 gaps");
      check_inst(1, 2, "crc8 gaps");
    end

    // R8: valid samples outside any frame
    clear_caps();
    for (int i = 0; i < 9; i++) drive(4'(i * 5), 1'b0, i == 4, 1'b1);
    flush();
    check(cnt[0] == 0 && cnt[1] == 0, "R8", "stray samples produced output",
          cnt[0] + cnt[1], 0);
    build_payload(5, 9);
    append16();
    send_frame(1'b0);
    check_inst(0, 4, "crc16 after strays R8");
    check_inst(1, 2, "crc8 after strays R8");

    // R9: start inside an unfinished frame
    clear_caps();
    build_payload(6, 11);
    append16();
    for (int i = 0; i < 7; i++) drive(fr[i], i == 0, 1'b0, 1'b1);
    drive(4'h0, 1'b0, 1'b0, 1'b0);
    drive(4'h0, 1'b0, 1'b0, 1'b0);
    check(cnt[0] == 3, "R9", "aborted part output count", cnt[0], 3);
    check(!cap_e[0][0] && !cap_e[0][1] && !cap_e[0][2], "R9", "aborted frame end",
          {cap_e[0][0], cap_e[0][1], cap_e[0][2]}, 0);
    clear_caps();
    build_payload(7, 13);
    append16();
    send_frame(1'b0);
    check(err_cap[0] == 16'h0, "R9", "frame after abort", err_cap[0], 0);
    check_inst(0, 4, "crc16 after abort");
    check_inst(1, 2, "crc8 after abort");

    // R10: checksum-only and single-sample frames
    clear_caps();
    build_payload(0, 0);
    append16();
    send_frame(1'b0);
    check(cnt[0] == 0, "R10", "checksum-only frame crc16", cnt[0], 0);
    check(cnt[1] == 2, "R10", "same frame crc8 payload", cnt[1], 2);
    clear_caps();
    flen = 2; fr[0] = 4'h3; fr[1] = 4'hC;
    send_frame(1'b0);
    check(cnt[0] == 0 && cnt[1] == 0, "R10", "two-sample frame", cnt[0] + cnt[1], 0);
    clear_caps();
    flen = 1; fr[0] = 4'h9;
    send_frame(1'b0);
    check(cnt[0] == 0 && cnt[1] == 0, "R10", "single-sample frame", cnt[0] + cnt[1], 0);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule